// File: doc/BRIEF.md
# Soft-Ramped Channel Gain Stage

This block scales one channel of signed 16-bit audio on its way into an output mixer. A 7-bit two's-complement gain code selects an attenuation or boost in half-decibel steps, and a separate mute bit silences the channel. The block turns the code into a linear coefficient, multiplies each accepted sample by it, then rounds and saturates the product to the sample width. The result leaves through a registered output stage.

Changes to gain and mute are sequenced by a 2-bit mode field. A change can be applied at once, or held until the signal crosses zero. It can also be walked toward the target one half-dB step per sample-rate tick, or walked one step per tick with each step landing on a crossing. Muting is treated as one extra step below the lowest gain, so a ramped mute fades out and a ramped unmute fades in. The gain, mute and mode fields are captured only in cycles where the processing enable is high.

Samples enter and leave on valid/ready streams. An input sample is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure on `m_ready` stalls the input after one sample. A stalled output holds its data unchanged until it is taken.

Top module: `mix_gain_stage`

## Requirements
- R1: After reset the captured gain code is 0x00, mute is engaged and the mode is immediate (00). Every accepted sample then produces 0, `ramp_done` is high, `m_valid` is low and `s_ready` is high.
- R2: The gain code is read as two's complement with 0.5 dB per LSB. Its gain index is L = (code + 103) mod 128, so 0x19 is the minimum (-51.5 dB, L=0), 0x7F is -0.5 dB, 0x00 is 0 dB (L=103) and 0x18 is the maximum (+12 dB, L=127). Codes above 0x18 never give a boost.
- R3: For index L, let d = 127 - L, q = d / 12 and r = d mod 12. The coefficient is min(M[r] >> q, 65535) as unsigned Q2.14. M[0..11] = 65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792.
- R4: The output sample is floor((x * coef + 8192) / 16384), saturated to the range -32768..32767. It appears on `m_data` with `m_valid` high on the clock edge that accepts x.
- R5: While the applied state is muted, every accepted sample produces exactly 0.
- R6: `cfg_gain`, `cfg_mute` and `cfg_mode` are captured only on edges where `proc_en` is 1. Otherwise they have no effect on the output or on `ramp_done`.
- R7: `s_ready` is high when `m_valid` is low or `m_ready` is high. While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold.
- R8: Mode 00 applies the captured target on the edge after capture.
- R9: Mode 10 moves the applied level one step toward the target on each edge where `fs_tick` is high. The mute state is the step below L=0, so muting from index L takes L+1 ticks and unmuting to L takes L+1 ticks.
- R10: A zero crossing is an accepted sample whose sign bit differs from that of the previous accepted sample. The sample that makes the crossing is still scaled by the old gain.
- R11: Mode 01 holds a change until a zero crossing and then applies the whole change at once.
- R12: In modes 01 and 11, if 1024 `fs_tick` pulses pass without a crossing while a change is pending, the 1024th tick applies the pending change (mode 01) or the pending step (mode 11).
- R13: Mode 11 takes at most one step per tick. A step becomes allowed at a tick and lands on the next zero crossing, and a second crossing before the next tick does not step.
- R14: `ramp_done` is high exactly when the applied level equals the captured target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with s_valid |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 16 | Signed scaled sample |
| fs_tick | input | 1 | One-cycle sample-rate pulse pacing ramps and timeout |
| proc_en | input | 1 | Capture enable for the configuration fields |
| cfg_mode | input | 2 | 00 immediate, 01 zero-cross, 10 ramp, 11 ramp on zero-cross |
| cfg_gain | input | 7 | Two's-complement gain code, 0.5 dB per LSB |
| cfg_mute | input | 1 | 1 mutes the channel |
| ramp_done | output | 1 | Applied level equals target |

## Verification
Two functions can fall in one cycle: accepting a sample, and changing the applied gain when that same sample is the zero crossing. The bench drives a run of same-sign samples, then one sample of opposite sign. It checks that this crossing sample comes out scaled by the old coefficient and the following sample by the new one. In mode 11 a tick and a crossing are placed on separate edges. The bench then sends a second crossing without a tick and checks from the output level that no extra step was taken.

// File: rtl/mgs_pkg.sv
package mgs_pkg;
  localparam int CODE_W        = 7;
  localparam int LVL_W         = CODE_W + 1;
  localparam int COEF_W        = 16;
  localparam int COEF_FRAC     = 14;
  localparam int STEPS_PER_OCT = 12;
  localparam int CODE_OFFSET   = 103;

  typedef enum logic [1:0] {
    MODE_NOW     = 2'b00,
    MODE_ZC      = 2'b01,
    MODE_RAMP    = 2'b10,
    MODE_RAMP_ZC = 2'b11
  } seq_mode_e;

  // mantissa for one half-dB position inside a 6 dB octave, Q3.14
  function automatic logic [COEF_W:0] oct_mant(input logic [3:0] r);
    logic [COEF_W:0] m;
    case (r)
      4'd0:    m = 17'd65536;
      4'd1:    m = 17'd61870;
      4'd2:    m = 17'd58409;
      4'd3:    m = 17'd55142;
      4'd4:    m = 17'd52057;
      4'd5:    m = 17'd49145;
      4'd6:    m = 17'd46396;
      4'd7:    m = 17'd43801;
      4'd8:    m = 17'd41350;
      4'd9:    m = 17'd39037;
      4'd10:   m = 17'd36854;
      4'd11:   m = 17'd34792;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mgs_coef_lut.sv
module mgs_coef_lut
  import mgs_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl,
  output logic [COEF_W-1:0] coef
);
  logic [CODE_W-1:0] atten;
  logic [3:0]        oct;
  logic [3:0]        pos;
  logic [COEF_W:0]   shifted;

  always_comb begin
    // level 0 is mute; levels 1..128 map to index 0..127
    atten   = ~(lvl[CODE_W-1:0] - CODE_W'(1));
    oct     = 4'(atten / CODE_W'(STEPS_PER_OCT));
    pos     = 4'(atten % CODE_W'(STEPS_PER_OCT));
    shifted = oct_mant(pos) >> oct;
    if (lvl == '0)
      coef = '0;
    else if (shifted[COEF_W])
      coef = '1;
    else
      coef = shifted[COEF_W-1:0];
  end
endmodule

// File: rtl/mgs_scaler.sv
module mgs_scaler
  import mgs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [COEF_W-1:0] coef,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(1) << (COEF_FRAC - 1);
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((longint'(1) << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  rounded;
  logic signed [SUM_W-1:0]  scaled;
  logic        [DATA_W-1:0] clipped;
  logic                     fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    prod    = $signed(in_data) * $signed({1'b0, coef});
    rounded = SUM_W'(prod) + HALF;
    scaled  = rounded >>> COEF_FRAC;
    if (scaled > SAT_HI)
      clipped = DATA_W'(SAT_HI);
    else if (scaled < SAT_LO)
      clipped = DATA_W'(SAT_LO);
    else
      clipped = DATA_W'(scaled);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= clipped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mgs_zc_watch.sv
module mgs_zc_watch #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic sign,
  input  logic tick,
  input  logic waiting,
  input  logic step,
  output logic zc,
  output logic tmo
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             prev_sign;
  logic [CNT_W-1:0] wait_cnt;

  assign zc  = fire && (sign != prev_sign);
  assign tmo = waiting && tick && (wait_cnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sign <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      if (fire)
        prev_sign <= sign;
      if (!waiting || step)
        wait_cnt <= '0;
      else if (tick)
        wait_cnt <= wait_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mgs_sequencer.sv
module mgs_sequencer
  import mgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seq_mode_e        mode,
  input  logic [LVL_W-1:0] tgt,
  input  logic             tick,
  input  logic             zc,
  input  logic             tmo,
  output logic [LVL_W-1:0] cur,
  output logic             step,
  output logic             waiting,
  output logic             done
);
  logic at_tgt, jump, nudge, armed;

  always_comb begin
    at_tgt = (cur == tgt);
    jump   = 1'b0;
    nudge  = 1'b0;
    case (mode)
      MODE_NOW:     jump  = !at_tgt;
      MODE_ZC:      jump  = !at_tgt && (zc || tmo);
      MODE_RAMP:    nudge = !at_tgt && tick;
      MODE_RAMP_ZC: nudge = !at_tgt && (armed || tick) && (zc || tmo);
      default:      ;
    endcase
  end

  assign step    = jump || nudge;
  assign waiting = mode[0] && !at_tgt;
  assign done    = at_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      armed <= 1'b0;
    end else begin
      if (jump)
        cur <= tgt;
      else if (nudge)
        cur <= (tgt > cur) ? cur + LVL_W'(1) : cur - LVL_W'(1);
      if (at_tgt || nudge)
        armed <= 1'b0;
      else if (tick)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/mix_gain_stage.sv
module mix_gain_stage
  import mgs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ZC_TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              fs_tick,
  input  logic              proc_en,
  input  logic [1:0]        cfg_mode,
  input  logic [CODE_W-1:0] cfg_gain,
  input  logic              cfg_mute,
  output logic              ramp_done
);
  logic [CODE_W-1:0] gain_q;
  logic              mute_q;
  seq_mode_e         mode_q;
  logic [CODE_W-1:0] gain_idx;
  logic [LVL_W-1:0]  tgt_e;
  logic [LVL_W-1:0]  cur_e;
  logic [COEF_W-1:0] coef;
  logic              fire, zc, tmo, step, waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      mute_q <= 1'b1;
      mode_q <= MODE_NOW;
    end else if (proc_en) begin
      gain_q <= cfg_gain;
      mute_q <= cfg_mute;
      mode_q <= seq_mode_e'(cfg_mode);
    end
  end

  assign gain_idx = gain_q + CODE_W'(CODE_OFFSET);
  assign tgt_e    = mute_q ? '0 : LVL_W'(gain_idx) + LVL_W'(1);
  assign fire     = s_valid && s_ready;

  mgs_zc_watch #(.TIMEOUT(ZC_TIMEOUT)) u_zc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sign(s_data[DATA_W-1]),
    .tick(fs_tick), .waiting(waiting), .step(step), .zc(zc), .tmo(tmo)
  );

  mgs_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .tgt(tgt_e), .tick(fs_tick),
    .zc(zc), .tmo(tmo), .cur(cur_e), .step(step), .waiting(waiting),
    .done(ramp_done)
  );

  mgs_coef_lut u_lut (.lvl(cur_e), .coef(coef));

  mgs_scaler #(.DATA_W(DATA_W)) u_scl (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready),
    .in_data(s_data), .coef(coef), .out_valid(m_valid),
    .out_ready(m_ready), .out_data(m_data)
  );
endmodule

// File: rtl/mgs_checker.sv
module mgs_checker #(
  parameter int DATA_W = 16,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              fs_tick,
  input logic              proc_en,
  input logic              ramp_done,
  input logic [LVL_W-1:0]  cur_e,
  input logic [1:0]        mode_q
);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_mute_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && cur_e == '0) |=> (m_data == '0));

  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && !proc_en) |=>
      (cur_e == $past(cur_e) || cur_e == $past(cur_e) + LVL_W'(1) ||
       cur_e == $past(cur_e) - LVL_W'(1)));

  p_tick_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && !fs_tick && !proc_en) |=> $stable(cur_e));

  p_zc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && !(s_valid && s_ready) && !fs_tick && !proc_en) |=> $stable(cur_e));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && !proc_en) |=> ramp_done);
endmodule

bind mix_gain_stage mgs_checker #(.DATA_W(DATA_W), .LVL_W(mgs_pkg::LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .fs_tick(fs_tick),
  .proc_en(proc_en), .ramp_done(ramp_done), .cur_e(cur_e), .mode_q(mode_q)
);

// File: tb/mix_gain_stage_tb.sv
module mix_gain_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, m_ready = 1'b1, fs_tick = 1'b0, proc_en = 1'b0;
  logic [15:0] s_data = '0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [6:0]  cfg_gain = 7'h00;
  logic        cfg_mute = 1'b1;
  logic        s_ready, m_valid, ramp_done;
  logic [15:0] m_data;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mix_gain_stage u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .fs_tick(fs_tick),
    .proc_en(proc_en), .cfg_mode(cfg_mode), .cfg_gain(cfg_gain), .cfg_mute(cfg_mute),
    .ramp_done(ramp_done)
  );

  function automatic longint mant(input int r);
    case (r)
      0: return 65536;  1: return 61870;  2: return 58409;  3: return 55142;
      4: return 52057;  5: return 49145;  6: return 46396;  7: return 43801;
      8: return 41350;  9: return 39037; 10: return 36854; default: return 34792;
    endcase
  endfunction

  // extended level: 0 is mute, otherwise gain index + 1
  function automatic int lvl_of(input int code);
    return ((code + 103) % 128) + 1;
  endfunction

  function automatic longint coef_of(input int e);
    int d;
    longint c;
    if (e == 0) return 0;
    d = 127 - (e - 1);
    c = mant(d % 12) >> (d / 12);
    return (c > 65535) ? 65535 : c;
  endfunction

  function automatic longint scale(input int x, input int e);
    longint y;
    y = (longint'(x) * coef_of(e) + 8192) >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int e, input string req);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = 16'(x);
    @(negedge clk);
    s_valid = 1'b0;
    chk(req, m_valid ? longint'($signed(m_data)) : 99999, scale(x, e));
  endtask

  task automatic tick();
    @(negedge clk) fs_tick = 1'b1;
    @(negedge clk) fs_tick = 1'b0;
  endtask

  task automatic write(input int code, input bit mute, input int mode);
    @(negedge clk);
    cfg_gain = 7'(code); cfg_mute = mute; cfg_mode = 2'(mode); proc_en = 1'b1;
    @(negedge clk) proc_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int seed_dummy;
    int codes[6];
    seed_dummy = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ramp_done", ramp_done, 1);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 s_ready", s_ready, 1);
    send(12000, 0, "R1 muted output");

    // R6 fields ignored while proc_en low
    cfg_mute = 1'b0; cfg_gain = 7'h18; cfg_mode = 2'b00;
    repeat (3) @(negedge clk);
    send(12000, 0, "R6 still muted");
    chk("R6 ramp_done", ramp_done, 1);

    // R8 immediate apply, R2/R3/R4 mapping with directed corner codes
    codes = '{7'h18, 7'h19, 7'h00, 7'h7F, 7'h67, 7'h68};
    foreach (codes[i]) begin
      write(codes[i], 1'b0, 0);
      chk("R8 done after apply", ramp_done, 1);
      send(32767, lvl_of(codes[i]), "R4 positive full scale");
      send(-32768, lvl_of(codes[i]), "R4 negative full scale");
      send(1000, lvl_of(codes[i]), "R2 mapping");
    end
    write(7'h00, 1'b0, 0);
    send(-4321, 104, "R2 unity at 0x00");
    cfg_gain = 7'h18;
    repeat (3) @(negedge clk);
    send(-4321, 104, "R6 gain held without enable");

    // R3 random codes and samples
    for (int k = 0; k < 14; k++) begin
      int c;
      c = int'($urandom_range(0, 127));
      write(c, 1'b0, 0);
      for (int j = 0; j < 6; j++)
        send(int'($urandom_range(0, 65535)) - 32768, lvl_of(c), "R3 random");
    end

    // R7 back-pressure
    write(7'h00, 1'b0, 0);
    m_ready = 1'b0;
    @(negedge clk); s_valid = 1'b1; s_data = 16'(777);
    @(negedge clk); s_data = 16'(-555);
    chk("R7 stall ready", s_ready, 0);
    repeat (3) @(negedge clk);
    chk("R7 hold data", $signed(m_data), 777);
    chk("R7 hold valid", m_valid, 1);
    m_ready = 1'b1;
    @(negedge clk); s_valid = 1'b0;
    chk("R7 drained next", $signed(m_data), -555);

    // R9 ramp 20 steps down
    write(7'h6C, 1'b0, 2);
    chk("R14 pending", ramp_done, 0);
    for (int k = 1; k <= 20; k++) begin
      tick();
      chk("R14 ramp progress", ramp_done, (k == 20) ? 1 : 0);
      if (k % 5 == 0) send(12345, 104 - k, "R9 step level");
    end
    // R9 mute fade from E=84
    write(7'h6C, 1'b1, 2);
    repeat (83) tick();
    chk("R14 not yet muted", ramp_done, 0);
    send(32767, 1, "R9 lowest before mute");
    tick();
    chk("R14 muted", ramp_done, 1);
    send(32767, 0, "R5 muted after fade");
    write(7'h6C, 1'b0, 2);
    tick();
    send(32767, 1, "R9 unmute first step");

    // R11/R10 zero-cross apply
    write(7'h00, 1'b0, 0);
    send(500, 104, "R10 prime sign");
    write(7'h74, 1'b0, 1);
    chk("R11 pending", ramp_done, 0);
    send(1000, 104, "R11 no crossing keeps gain");
    send(-1000, 104, "R10 crossing sample old gain");
    chk("R11 applied", ramp_done, 1);
    send(-1000, 92, "R11 new gain");

    // R12 timeout
    write(7'h00, 1'b0, 1);
    send(-7, 92, "R12 same sign");
    repeat (1023) tick();
    chk("R12 before limit", ramp_done, 0);
    tick();
    chk("R12 at limit", ramp_done, 1);
    send(-3000, 104, "R12 forced gain");

    // R13 ramp on crossings, one step per tick
    write(7'h02, 1'b0, 3);
    send(-100, 104, "R13 no crossing");
    tick();
    send(-100, 104, "R13 tick alone");
    send(100, 104, "R13 crossing carries old");
    send(100, 105, "R13 one step");
    send(-100, 105, "R13 second crossing no tick");
    chk("R13 pending", ramp_done, 0);
    tick();
    send(-100, 105, "R13 still waiting");
    send(100, 105, "R13 crossing step two");
    chk("R14 reached", ramp_done, 1);
    send(100, 106, "R13 final level");

    finish_run();
  end
endmodule